// File: doc/BRIEF.md
# Vector Serializer with Idle Padding

This block takes a packed vector of `NUM_ELEMS` elements and sends it out over `RATIO` consecutive beats. Each beat carries `NUM_ELEMS/RATIO` elements, so `RATIO == NUM_ELEMS` gives a scalar stream. After the data beats, `IDLE_CYCLES` padding beats follow. One vector therefore takes exactly `RATIO + IDLE_CYCLES` clock cycles, which is one frame.

A load strobe marks the slow-rate sample. On an accepted strobe the vector and its validity flag are copied into a holding register, and the frame starts on the next cycle.

The data path always runs. The validity flag only gates the two markers:
- `valid_out` is high on every data beat of a valid frame.
- `start_out` is high on the first beat of a valid frame.

A strobe is accepted in either of two cases:
- No frame is in progress.
- The current frame is on its final beat. This allows back-to-back frames.

Strobes at any other time are ignored.

Top module: `vser_top`

## Requirements
- R1: Element i of `data_in` sits at bits [i*ELEM_W +: ELEM_W]. Beat j of a frame carries elements j*EPB through j*EPB+EPB-1, where EPB = NUM_ELEMS/RATIO, with the lowest-indexed element in the low bits of `data_out`. Element 0 is therefore sent first.
- R2: A strobe accepted at a rising edge makes beat 0 appear in the following cycle. The frame lasts exactly RATIO+IDLE_CYCLES cycles.
- R3: The IDLE_CYCLES padding beats come after the RATIO data beats. On padding beats `data_out` is zero and `valid_out` is low.
- R4: The `data_out` sequence of a frame is the same whether `valid_in` was high or low at capture.
- R5: A frame captured with `valid_in` low keeps `valid_out` and `start_out` low for all its beats.
- R6: In a frame captured with `valid_in` high, `start_out` is high on beat 0 only.
- R7: In a frame captured with `valid_in` high, `valid_out` is high on every data beat.
- R8: Changes to `data_in` or `valid_in` during a frame do not affect that frame. A `load` strobe that arrives before the final beat is ignored.
- R9: A `load` strobe on the final beat of a frame starts the next frame in the very next cycle, with no gap.
- R10: A synchronous active-high `rst` ends any frame. After reset, `data_out` is zero and `valid_out` and `start_out` are low until the next accepted strobe.
- R11: When no frame is in progress, `data_out` is zero and both markers are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Slow-rate strobe that requests capture of a new vector |
| valid_in | input | 1 | Validity of the vector offered with `load` |
| data_in | input | NUM_ELEMS*ELEM_W | Packed input vector, element 0 in the low bits |
| data_out | output | (NUM_ELEMS/RATIO)*ELEM_W | Current beat's elements |
| valid_out | output | 1 | High on data beats of a valid frame |
| start_out | output | 1 | High on the first beat of a valid frame |

## Verification
The bench builds two copies side by side, both with four 8-bit elements and the same stimulus. The first uses RATIO=2 and IDLE_CYCLES=2, which exercises two-element sub-vectors followed by padding beats. The second uses RATIO=4 and IDLE_CYCLES=0, which exercises a scalar stream whose final beat is also its last data beat, so back-to-back frames leave no gap at all. Both copies have a four-cycle frame, so ignored mid-frame strobes, final-beat restarts and a mid-frame reset are compared in the same cycles in both shapes.

// File: rtl/vser_pkg.sv
package vser_pkg;

    // Per-cycle beat status from the frame controller
    typedef struct packed {
        logic active;     // a frame is in progress
        logic data_beat;  // current beat carries data
        logic first;      // current beat is beat 0
    } beat_info_t;

    // Counter width able to hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/vser_ctrl.sv
module vser_ctrl
    import vser_pkg::*;
#(
    parameter int RATIO       = 4,
    parameter int IDLE_CYCLES = 2,
    parameter int CNT_W       = cnt_width(RATIO + IDLE_CYCLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic             capture,
    output logic [CNT_W-1:0] beat,
    output beat_info_t       info
);
    localparam int FRAME_LEN = RATIO + IDLE_CYCLES;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(RATIO);

    logic             active_q;
    logic [CNT_W-1:0] beat_q;
    logic             last;

    assign last    = active_q && (beat_q == LAST_BEAT);
    assign capture = load && (!active_q || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (capture) begin
            active_q <= 1'b1;
            beat_q   <= '0;
        end else if (last) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (active_q) begin
            beat_q   <= beat_q + 1'b1;
        end
    end

    assign beat           = beat_q;
    assign info.active    = active_q;
    assign info.data_beat = active_q && (beat_q < DATA_END);
    assign info.first     = active_q && (beat_q == '0);

    // R8
    ignored_load_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !last && load) |=> (active_q && beat_q == $past(beat_q) + 1'b1));

    // R2
    beat_range_chk: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (beat_q <= LAST_BEAT));

endmodule

// File: rtl/vser_hold.sv
module vser_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] data_in,
    input  logic              valid_in,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data  <= '0;
            hold_valid <= 1'b0;
        end else if (capture) begin
            hold_data  <= data_in;
            hold_valid <= valid_in;
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(hold_data) && $stable(hold_valid)));

endmodule

// File: rtl/vser_mux.sv
module vser_mux #(
    parameter int ELEM_W    = 8,
    parameter int NUM_ELEMS = 4,
    parameter int RATIO     = 4,
    parameter int CNT_W     = 3
) (
    input  logic [NUM_ELEMS*ELEM_W-1:0]         hold_data,
    input  logic [CNT_W-1:0]                    beat,
    input  logic                                data_beat,
    output logic [(NUM_ELEMS/RATIO)*ELEM_W-1:0] data_out
);
    localparam int EPB   = NUM_ELEMS / RATIO;
    localparam int OUT_W = EPB * ELEM_W;

    logic [OUT_W-1:0] slices [RATIO];
    logic [OUT_W-1:0] sel;

    for (genvar g = 0; g < RATIO; g++) begin : g_slice
        assign slices[g] = hold_data[g*OUT_W +: OUT_W];
    end

    always_comb begin
        sel = '0;
        for (int j = 0; j < RATIO; j++) begin
            if (beat == CNT_W'(j)) sel = slices[j];
        end
    end

    assign data_out = data_beat ? sel : '0;

endmodule

// File: rtl/vser_top.sv
module vser_top
    import vser_pkg::*;
#(
    parameter int ELEM_W      = 8,
    parameter int NUM_ELEMS   = 4,
    parameter int RATIO       = 4,
    parameter int IDLE_CYCLES = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                load,
    input  logic                                valid_in,
    input  logic [NUM_ELEMS*ELEM_W-1:0]         data_in,
    output logic [(NUM_ELEMS/RATIO)*ELEM_W-1:0] data_out,
    output logic                                valid_out,
    output logic                                start_out
);
    localparam int DATA_W = NUM_ELEMS * ELEM_W;
    localparam int CNT_W  = cnt_width(RATIO + IDLE_CYCLES);

    if (RATIO < 1 || (NUM_ELEMS % RATIO) != 0) begin : g_bad_ratio
        $error("vser_top: NUM_ELEMS must be a multiple of RATIO");
    end
    if (IDLE_CYCLES < 0) begin : g_bad_idle
        $error("vser_top: IDLE_CYCLES must not be negative");
    end

    logic              capture;
    logic [CNT_W-1:0]  beat;
    beat_info_t        info;
    logic [DATA_W-1:0] hold_data;
    logic              hold_valid;

    vser_ctrl #(
        .RATIO       (RATIO),
        .IDLE_CYCLES (IDLE_CYCLES),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .capture (capture),
        .beat    (beat),
        .info    (info)
    );

    vser_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .data_in    (data_in),
        .valid_in   (valid_in),
        .hold_data  (hold_data),
        .hold_valid (hold_valid)
    );

    vser_mux #(
        .ELEM_W    (ELEM_W),
        .NUM_ELEMS (NUM_ELEMS),
        .RATIO     (RATIO),
        .CNT_W     (CNT_W)
    ) u_mux (
        .hold_data (hold_data),
        .beat      (beat),
        .data_beat (info.data_beat),
        .data_out  (data_out)
    );

    assign valid_out = info.data_beat && hold_valid;
    assign start_out = info.first && hold_valid;

    // R6
    start_valid_chk: assert property (@(posedge clk) disable iff (rst)
        start_out |-> valid_out);

    // R6
    start_once_chk: assert property (@(posedge clk) disable iff (rst)
        (start_out && !capture) |=> !start_out);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (info.active && !info.data_beat) |-> (!valid_out && data_out == '0));

    // R5
    invalid_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (capture && !valid_in) |=> (!valid_out && !start_out));

    // R11
    no_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !info.active |-> (!valid_out && !start_out && data_out == '0));

endmodule

// File: tb/vser_top_bench.sv
module vser_top_bench;

    typedef struct {
        logic [15:0] d;
        bit          v;
        bit          s;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic        valid_in = 1'b0;
    logic [31:0] data_in = '0;

    logic [15:0] a_data;
    logic        a_valid, a_start;
    logic [7:0]  b_data;
    logic        b_valid, b_start;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    exp_t qa[$];
    exp_t qb[$];

    always #10 clk = ~clk;

    // Sub-vector shape with padding
    vser_top #(.ELEM_W(8), .NUM_ELEMS(4), .RATIO(2), .IDLE_CYCLES(2)) u_vser_top (
        .clk(clk), .rst(rst), .load(load), .valid_in(valid_in), .data_in(data_in),
        .data_out(a_data), .valid_out(a_valid), .start_out(a_start)
    );

    // Scalar shape without padding
    vser_top #(.ELEM_W(8), .NUM_ELEMS(4), .RATIO(4), .IDLE_CYCLES(0)) u_vser_top_scalar (
        .clk(clk), .rst(rst), .load(load), .valid_in(valid_in), .data_in(data_in),
        .data_out(b_data), .valid_out(b_valid), .start_out(b_start)
    );

    task automatic check(string who, logic [15:0] act_d, bit act_v, bit act_s, exp_t e);
        n_cmp++;
        if (act_d !== e.d || act_v !== e.v || act_s !== e.s) begin
            n_bad++;
            $display("FAIL %s %s: data=%h valid=%b start=%b expected data=%h valid=%b start=%b",
                     cur_req, who, act_d, act_v, act_s, e.d, e.v, e.s);
        end
    endtask

    // Expected frame: ratio beats of (4/ratio) bytes each, low element first, then padding
    task automatic push_frame(ref exp_t q[$], input int ratio, input int idle,
                              input logic [31:0] d, input bit v);
        int w = (4 / ratio) * 8;
        for (int j = 0; j < ratio + idle; j++) begin
            exp_t e;
            if (j < ratio) e.d = 16'((d >> (j * w)) & ((32'd1 << w) - 1));
            else           e.d = '0;
            e.v = v && (j < ratio);
            e.s = v && (j == 0);
            q.push_back(e);
        end
    endtask

    task automatic step(bit r, bit ld, bit vi, logic [31:0] d);
        exp_t ea, eb, zero;
        zero.d = '0; zero.v = 1'b0; zero.s = 1'b0;
        @(negedge clk);
        ea = (qa.size() > 0) ? qa[0] : zero;
        eb = (qb.size() > 0) ? qb[0] : zero;
        check("sub-vector", a_data, a_valid, a_start, ea);
        check("scalar", {8'h00, b_data}, b_valid, b_start, eb);
        if (r) begin
            qa.delete();
            qb.delete();
        end else begin
            if (qa.size() > 0) void'(qa.pop_front());
            if (qb.size() > 0) void'(qb.pop_front());
            if (ld && qa.size() == 0) push_frame(qa, 2, 2, d, vi);
            if (ld && qb.size() == 0) push_frame(qb, 4, 0, d, vi);
        end
        rst = r; load = ld; valid_in = vi; data_in = d;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        cur_req = "R10";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 32'h0);
        // R11: no frame in progress
        cur_req = "R11";
        for (int i = 0; i < 3; i++) step(0, 0, 1, 32'hFFFF_FFFF);
        // R5 / R4: invalid frame still streams data
        cur_req = "R5";
        step(0, 1, 0, 32'hD4C3_B2A1);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 32'h0);
        // R1 / R6 / R7 / R3: valid frame
        cur_req = "R1";
        step(0, 1, 1, 32'h4433_2211);
        cur_req = "R6";
        for (int i = 0; i < 4; i++) step(0, 0, 0, 32'h0);
        cur_req = "R11";
        step(0, 0, 0, 32'h0);
        // R8: input change and strobes mid-frame are ignored
        cur_req = "R8";
        step(0, 1, 1, 32'h8877_6655);
        step(0, 1, 0, 32'hAAAA_AAAA);
        step(0, 1, 0, 32'hBBBB_BBBB);
        step(0, 0, 0, 32'hCCCC_CCCC);
        // R9 / R2: strobe held high, restart on each final beat
        cur_req = "R9";
        step(0, 1, 1, 32'h0102_0304);
        for (int i = 0; i < 11; i++)
            step(0, 1, (i % 2) == 0, 32'h1000_0000 + 32'(i) * 32'h0011_2233);
        cur_req = "R2";
        for (int i = 0; i < 6; i++) step(0, 0, 1, 32'h0);
        // R4: same vector, valid high, for data comparison
        cur_req = "R4";
        step(0, 1, 1, 32'hD4C3_B2A1);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 32'h0);
        // R7: scalar stream boundary element values
        cur_req = "R7";
        step(0, 1, 1, 32'hFF00_FF00);
        for (int i = 0; i < 2; i++) step(0, 0, 0, 32'h0);
        // R10: reset in the middle of a frame
        cur_req = "R10";
        step(1, 0, 0, 32'h0);
        step(0, 0, 0, 32'h0);
        step(0, 0, 0, 32'h0);
        cur_req = "R3";
        step(0, 1, 1, 32'h5A5A_A5A5);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule